// File: doc/BRIEF.md
# Host Memory Access Slave Port

This block lets an external host reach a processor's internal program memory (24-bit words) and data memory (16-bit words) through a 16-bit multiplexed address/data bus. The host drives its strobes without reference to the processor clock, and the core keeps running at full speed while the host works. The host first sends a latch word. Depending on bit 15, that word loads either a start address with a memory space, or an overlay selector. The host then issues read or write strobes. Each one moves one bus word, and the address steps forward on its own, so a block transfer needs only one latch word.

On the internal side the port drives a single-cycle memory request, with write enable, space select, address and write data. Read data returns on the cycle after the request. A program word travels as two bus accesses but costs one memory request. The port also holds off core execution after a boot-mode reset, until the host completes a program-memory write to address zero. The bus is split into an input half, an output half and an output enable, ready for a bidirectional pad.

Top module: `host_mem_port`

## Requirements
- R1: During and right after reset, hostAck is 1, ovlySel is 0, latchErr is 0, memReq is 0, and coreHold equals bootMode.
- R2: A latch word is taken when hostLatch falls while hostSel is high. If bit 15 is 0, bits 13:0 become the start address and bit 14 picks the space (1 = program, 0 = data). The pending half-word position also restarts.
- R3: A latch word with bit 15 = 1 and bits 14:8 all zero loads bits 7:0 into ovlySel.
- R4: A latch word with bit 15 = 1 and any of bits 14:8 set raises latchErr for one cycle. It leaves ovlySel, the address and the space unchanged.
- R5: hostAck falls on the third clock edge after a read or write strobe rises. It stays low for exactly three cycles, and memReq pulses for at most one of them. Read data is valid on hostDataOut once hostAck is high again.
- R6: Each data-memory access makes one memory request. Its 16-bit word sits in memWData[15:0] and memRData[15:0]. The address then goes up by one, and 0x3FFF wraps to 0x0000.
- R7: A program word takes two accesses, bits 23:8 first and then bits 7:0 in bus bits 7:0. On the second read, bus bits 15:8 are zero; on the second write they are ignored. Each pair makes exactly one memory request: the read on the first access, the write on the second. The address goes up only after the second access.
- R8: Once cleared, coreHold never sets again until reset. It clears only when a program-memory write to address 0 is requested. Data writes to address 0 and a lone first half leave it set.
- R9: hostDataOe is high exactly while hostSel and hostRd are both high.
- R10: Read or write strobes given while hostSel is low start no access and leave hostAck high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootMode | input | 1 | Host boot selected; sets coreHold at reset |
| hostSel | input | 1 | Host port select, active high |
| hostLatch | input | 1 | Host address-latch strobe, active high |
| hostRd | input | 1 | Host read strobe, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostDataIn | input | 16 | Bus value driven by the host |
| hostDataOut | output | 16 | Read data toward the host |
| hostDataOe | output | 1 | Output enable for the bus pads |
| hostAck | output | 1 | High when the port can accept a new access |
| memReq | output | 1 | Single-cycle internal memory request |
| memWe | output | 1 | Request is a write |
| memIsPm | output | 1 | Request targets program memory |
| memAddr | output | 14 | Word address of the request |
| memWData | output | 24 | Write data (data memory uses bits 15:0) |
| memRData | input | 24 | Read data, valid the cycle after the request |
| ovlySel | output | 8 | Overlay selector loaded by the host |
| latchErr | output | 1 | One-cycle pulse on a malformed overlay word |
| coreHold | output | 1 | Holds core execution during host boot |

## Verification
Most wrong internal states show up at the ports. A wrong address or space register sends the next access to the wrong location, and a readback of a swept block finds this at the first wrong word. A wrong half-word flag swaps the two program halves, or changes the memory-request count on the very next access. A controller stuck outside idle keeps hostAck low, so the three-cycle busy window gets longer and the access times out. A hold flag that clears too early is seen as soon as the first program half, or a data write to address zero, completes.

// File: rtl/hmpPkg.sv
package hmpPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_ACC, ST_FIN} hmpState_t;

  typedef struct packed {
    logic latchDo;   // decode the word on the bus as a latch word
    logic capWr;     // capture write data from the bus
    logic memReq;    // issue the internal memory request
    logic finish;    // complete the access: data moves, half/address update
    logic isWrite;   // current access direction
  } hmpStrobes_t;
endpackage

// File: rtl/hmpSync.sv
module hmpSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hmpCtrl.sv
module hmpCtrl
  import hmpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selS,
  input  logic        latchS,
  input  logic        rdS,
  input  logic        wrS,
  input  logic        isPm,
  input  logic        half,
  output hmpStrobes_t strb,
  output logic        hostAck
);
  hmpState_t state, stateNext;
  logic latchPrev, rdPrev, wrPrev;
  logic isWriteQ;
  logic latchFall, rdRise, wrRise, startAcc, needMem;

  assign latchFall = latchPrev & ~latchS & selS;
  assign rdRise    = rdS & ~rdPrev & selS;
  assign wrRise    = wrS & ~wrPrev & selS;
  assign startAcc  = ~latchFall & (rdRise | wrRise);

  // program reads fetch on the first half, program writes store on the second
  assign needMem = ~isPm | (isWriteQ ? half : ~half);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchPrev <= 1'b0;
      rdPrev    <= 1'b0;
      wrPrev    <= 1'b0;
      state     <= ST_IDLE;
      isWriteQ  <= 1'b0;
    end else begin
      latchPrev <= latchS;
      rdPrev    <= rdS;
      wrPrev    <= wrS;
      state     <= stateNext;
      if (state == ST_IDLE && startAcc) isWriteQ <= wrRise;
    end
  end

  always_comb begin
    strb         = '0;
    strb.isWrite = isWriteQ;
    stateNext    = state;
    unique case (state)
      ST_IDLE: begin
        if (latchFall) begin
          strb.latchDo = 1'b1;
        end else if (startAcc) begin
          strb.capWr = wrRise;
          stateNext  = ST_SYNC;
        end
      end
      ST_SYNC: stateNext = ST_ACC;
      ST_ACC: begin
        strb.memReq = needMem;
        stateNext   = ST_FIN;
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign hostAck = (state == ST_IDLE);
endmodule

// File: rtl/hmpDatapath.sv
module hmpDatapath
  import hmpPkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16,
  parameter int PM_W   = 24,
  parameter int OVLY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootMode,
  input  hmpStrobes_t       strb,
  input  logic [BUS_W-1:0]  hostDataIn,
  input  logic [PM_W-1:0]   memRData,
  output logic [BUS_W-1:0]  hostDataOut,
  output logic              memReq,
  output logic              memWe,
  output logic              memIsPm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PM_W-1:0]   memWData,
  output logic [OVLY_W-1:0] ovlySel,
  output logic              latchErr,
  output logic              coreHold,
  output logic              isPm,
  output logic              half
);
  localparam int MODE_BIT = BUS_W - 1;
  localparam int LOW_W    = PM_W - BUS_W;

  logic [ADDR_W-1:0] addrQ;
  logic              pmQ, halfQ, errQ, holdQ;
  logic [OVLY_W-1:0] ovlyQ;
  logic [BUS_W-1:0]  wrStage, hiStage, outQ;
  logic [PM_W-1:0]   rdHold;
  logic              ovlyMode, resvClear;

  assign ovlyMode  = hostDataIn[MODE_BIT];
  assign resvClear = (hostDataIn[MODE_BIT-1:OVLY_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      pmQ     <= 1'b0;
      halfQ   <= 1'b0;
      errQ    <= 1'b0;
      holdQ   <= bootMode;
      ovlyQ   <= '0;
      wrStage <= '0;
      hiStage <= '0;
      outQ    <= '0;
      rdHold  <= '0;
    end else begin
      errQ <= 1'b0;
      if (strb.latchDo) begin
        if (ovlyMode) begin
          if (resvClear) ovlyQ <= hostDataIn[OVLY_W-1:0];
          else           errQ  <= 1'b1;
        end else begin
          addrQ <= hostDataIn[ADDR_W-1:0];
          pmQ   <= hostDataIn[ADDR_W];
          halfQ <= 1'b0;
        end
      end
      if (strb.capWr) wrStage <= hostDataIn;
      if (strb.memReq && strb.isWrite && pmQ && addrQ == '0) holdQ <= 1'b0;
      if (strb.finish) begin
        if (pmQ) begin
          halfQ <= ~halfQ;
          if (halfQ) addrQ <= addrQ + ADDR_W'(1);
          if (strb.isWrite) begin
            if (!halfQ) hiStage <= wrStage;
          end else if (!halfQ) begin
            rdHold <= memRData;
            outQ   <= memRData[PM_W-1:LOW_W];
          end else begin
            outQ <= {{(BUS_W-LOW_W){1'b0}}, rdHold[LOW_W-1:0]};
          end
        end else begin
          addrQ <= addrQ + ADDR_W'(1);
          if (!strb.isWrite) outQ <= memRData[BUS_W-1:0];
        end
      end
    end
  end

  assign memReq      = strb.memReq;
  assign memWe       = strb.isWrite;
  assign memIsPm     = pmQ;
  assign memAddr     = addrQ;
  assign memWData    = pmQ ? {hiStage, wrStage[LOW_W-1:0]} : {{LOW_W{1'b0}}, wrStage};
  assign hostDataOut = outQ;
  assign ovlySel     = ovlyQ;
  assign latchErr    = errQ;
  assign coreHold    = holdQ;
  assign isPm        = pmQ;
  assign half        = halfQ;
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmpPkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BUS_W       = 16,
  parameter int PM_W        = 24,
  parameter int OVLY_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootMode,
  input  logic              hostSel,
  input  logic              hostLatch,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [BUS_W-1:0]  hostDataIn,
  output logic [BUS_W-1:0]  hostDataOut,
  output logic              hostDataOe,
  output logic              hostAck,
  output logic              memReq,
  output logic              memWe,
  output logic              memIsPm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PM_W-1:0]   memWData,
  input  logic [PM_W-1:0]   memRData,
  output logic [OVLY_W-1:0] ovlySel,
  output logic              latchErr,
  output logic              coreHold
);
  localparam int STROBES = 4;

  logic [STROBES-1:0] rawStrobes, syncStrobes;
  hmpStrobes_t        strb;
  logic               isPm, half;

  assign rawStrobes = {hostSel, hostLatch, hostRd, hostWr};
  assign hostDataOe = hostSel & hostRd;

  hmpSync #(.WIDTH(STROBES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawStrobes),
    .dout (syncStrobes)
  );

  hmpCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selS    (syncStrobes[3]),
    .latchS  (syncStrobes[2]),
    .rdS     (syncStrobes[1]),
    .wrS     (syncStrobes[0]),
    .isPm    (isPm),
    .half    (half),
    .strb    (strb),
    .hostAck (hostAck)
  );

  hmpDatapath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .PM_W(PM_W), .OVLY_W(OVLY_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .bootMode    (bootMode),
    .strb        (strb),
    .hostDataIn  (hostDataIn),
    .memRData    (memRData),
    .hostDataOut (hostDataOut),
    .memReq      (memReq),
    .memWe       (memWe),
    .memIsPm     (memIsPm),
    .memAddr     (memAddr),
    .memWData    (memWData),
    .ovlySel     (ovlySel),
    .latchErr    (latchErr),
    .coreHold    (coreHold),
    .isPm        (isPm),
    .half        (half)
  );
endmodule

// File: rtl/hmpChecker.sv
module hmpChecker #(
  parameter int ADDR_W = 14,
  parameter int OVLY_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic              memReq,
  input logic              memWe,
  input logic              memIsPm,
  input logic [ADDR_W-1:0] memAddr,
  input logic [OVLY_W-1:0] ovlySel,
  input logic              latchErr,
  input logic              coreHold
);
  // R5: a memory request occupies a single cycle
  a_r5_req_single: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R5: the host sees the port busy while memory is being accessed
  a_r5_busy_ack: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !hostAck);

  // R8: the hold never comes back once cleared
  a_r8_hold_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(coreHold));

  // R8: release follows a program write to address zero
  a_r8_hold_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreHold) |-> $past(memReq && memWe && memIsPm && memAddr == '0));

  // R4: a malformed overlay word leaves the overlay alone
  a_r4_err_keeps_ovly: assert property (@(posedge clk) disable iff (!rstN)
    latchErr |-> $stable(ovlySel));
endmodule

bind host_mem_port hmpChecker #(.ADDR_W(ADDR_W), .OVLY_W(OVLY_W)) u_hmpChecker (.*);

// File: tb/test_host_mem_port.sv
module test_host_mem_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootMode = 1'b1;
  logic        hostSel = 1'b0, hostLatch = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostDataOe, hostAck, memReq, memWe, memIsPm, latchErr, coreHold;
  logic [13:0] memAddr;
  logic [23:0] memWData, memRData, rdReg;
  logic [7:0]  ovlySel;

  int checks = 0, fails = 0, reqCount = 0, errCount = 0;
  bit done = 0;

  logic [23:0] pmMem [256];
  logic [15:0] dmMem [256];

  always #2 clk = ~clk;

  host_mem_port i_host_mem_port (.*);

  always @(posedge clk) begin
    if (memReq) begin
      reqCount <= reqCount + 1;
      if (memWe) begin
        if (memIsPm) pmMem[memAddr[7:0]] <= memWData;
        else         dmMem[memAddr[7:0]] <= memWData[15:0];
      end else begin
        rdReg <= memIsPm ? pmMem[memAddr[7:0]] : {8'h00, dmMem[memAddr[7:0]]};
      end
    end
    if (latchErr) errCount <= errCount + 1;
  end
  assign memRData = rdReg;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic latchWord(logic [15:0] w);
    @(negedge clk);
    hostDataIn = w; hostSel = 1'b1; hostLatch = 1'b1;
    repeat (4) @(negedge clk);
    hostLatch = 1'b0;
    repeat (5) @(negedge clk);
    hostSel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic access(bit isWr, logic [15:0] wd, output logic [15:0] rd);
    int toLow = 0, lowLen = 0;
    @(negedge clk);
    hostDataIn = wd; hostSel = 1'b1;
    if (isWr) hostWr = 1'b1; else hostRd = 1'b1;
    while (hostAck && toLow < 20) begin @(negedge clk); toLow++; end
    while (!hostAck && lowLen < 20) begin @(negedge clk); lowLen++; end
    check("R5 ack fall delay", toLow, 3);
    check("R5 busy length", lowLen, 3);
    check("R9 output enable", hostDataOe, !isWr);
    rd = hostDataOut;
    hostWr = 1'b0; hostRd = 1'b0; hostSel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] dmPat(int i);
    return 16'hA000 ^ 16'(i * 16'h1357);
  endfunction
  function automatic logic [23:0] pmPat(int i);
    return 24'h123456 + 24'(i * 24'h10F0F1);
  endfunction

  initial begin
    logic [15:0] rd;
    int r0, e0;
    for (int i = 0; i < 256; i++) begin pmMem[i] = '0; dmMem[i] = '0; end
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 ack", hostAck, 1);
    check("R1 ovly", ovlySel, 0);
    check("R1 hold", coreHold, 1);
    check("R1 err", latchErr, 0);
    check("R1 req", memReq, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ack after reset", hostAck, 1);
    check("R1 hold after reset", coreHold, 1);

    // R3 overlay loads
    foreach (dmMem[k]) if (k < 4) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h5A : (k == 1) ? 8'hFF : (k == 2) ? 8'h81 : 8'h00;
      latchWord({8'h80, v});
      check("R3 overlay", ovlySel, v);
    end
    latchWord(16'h80C3);
    check("R3 overlay", ovlySel, 8'hC3);

    // R4 malformed overlay words, address unchanged
    latchWord(16'h0040);
    access(1, 16'h1111, rd);
    e0 = errCount;
    for (int b = 8; b < 15; b++) begin
      latchWord(16'h8000 | 16'(1 << b) | 16'h0050);
      check("R4 overlay kept", ovlySel, 8'hC3);
    end
    check("R4 error pulses", errCount - e0, 7);
    access(1, 16'h2222, rd);
    check("R4 address kept", dmMem[8'h41], 16'h2222);
    check("R4 no stray write", dmMem[8'h50], 16'h0000);

    // R2/R6 data memory block sweep
    latchWord(16'h0010);
    for (int i = 0; i < 16; i++) begin
      r0 = reqCount;
      access(1, dmPat(i), rd);
      check("R6 one request per data write", reqCount - r0, 1);
    end
    for (int i = 0; i < 16; i++) check("R6 data stored", dmMem[8'h10 + i], dmPat(i));
    latchWord(16'h0010);
    for (int i = 0; i < 16; i++) begin
      r0 = reqCount;
      access(0, 16'h0000, rd);
      check("R6 data readback", rd, dmPat(i));
      check("R6 one request per data read", reqCount - r0, 1);
    end

    // R6 wrap, R8 data write to zero keeps hold
    latchWord(16'h3FFF);
    access(1, 16'hBEEF, rd);
    access(1, 16'hCAFE, rd);
    check("R6 wrap top", dmMem[8'hFF], 16'hBEEF);
    check("R6 wrap zero", dmMem[8'h00], 16'hCAFE);
    check("R8 hold after data write to 0", coreHold, 1);

    // R7 program memory pairs
    latchWord(16'h4005);
    for (int i = 0; i < 4; i++) begin
      logic [23:0] g;
      g = pmPat(i);
      r0 = reqCount;
      access(1, g[23:8], rd);
      check("R7 no request on first half", reqCount - r0, 0);
      access(1, {8'hEE, g[7:0]}, rd);
      check("R7 one request per pair", reqCount - r0, 1);
      check("R7 program stored", pmMem[8'h05 + i], g);
    end
    check("R8 hold after other program writes", coreHold, 1);
    latchWord(16'h4005);
    for (int i = 0; i < 4; i++) begin
      logic [23:0] g;
      g = pmPat(i);
      r0 = reqCount;
      access(0, 16'h0000, rd);
      check("R7 upper half read", rd, g[23:8]);
      access(0, 16'h0000, rd);
      check("R7 lower half read", rd, {8'h00, g[7:0]});
      check("R7 one request per read pair", reqCount - r0, 1);
    end

    // R8 boot release
    latchWord(16'h4000);
    access(1, 16'h0102, rd);
    check("R8 hold after first half at 0", coreHold, 1);
    access(1, 16'h0003, rd);
    check("R8 hold released", coreHold, 0);
    check("R8 word at 0", pmMem[0], 24'h010203);

    // R10 strobes without select
    r0 = reqCount;
    @(negedge clk);
    hostRd = 1'b1;
    repeat (4) @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 ack stays high", hostAck, 1);
    end
    hostWr = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 no request", reqCount - r0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule